// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns a decoded operand request from a small 8-bit controller core into an address and an address space. Each cycle the core may present one request. The request carries a 3-bit mode code, the instruction's address or data byte, the accumulator, a 16-bit data pointer, a 2-bit register-bank select, a 3-bit register number and the current contents of the two pointer-capable registers of the active bank. One clock later the block reports the selected space and the address. The spaces are internal RAM, special-register space, code memory and external data memory.

Stack operations keep a private 8-bit stack pointer. A push or pop yields two addresses in the same cycle: the operand, which is always given as a direct byte address, and the stack slot, which is always in internal RAM. In immediate mode no address is produced. The operand byte is passed back instead. An indirect request that names any register other than the first two is flagged as illegal.

Top module: `opnd_addr_gen`

## Requirements
- R1: After reset all outputs are 0 and the stack pointer holds 07h, so the first push places its stack slot at 08h.
- R2: Mode 0 (immediate) yields out_addr_vld=0, out_addr=0, and out_imm equal to the request byte.
- R3: Mode 1 (register) yields space 0 (internal RAM) and address bank_sel*8 + reg_sel, so bank 3 register 7 gives 1Fh.
- R4: Mode 2 (direct) yields the request byte zero-extended as the address. The space is 0 (internal RAM) for 00h–7Fh and 1 (special registers) for 80h–FFh.
- R5: Mode 3 (indirect) with reg_sel 0 or 1 uses ptr_r0 or ptr_r1 as the address. The space follows the same 80h split as R4, so it is never 2 (code) or 3 (external data).
- R6: Mode 3 with reg_sel 2–7 sets out_illegal=1 and out_addr_vld=0, and produces no address.
- R7: Mode 4 (indexed) yields space 2 (code) and address dptr plus the zero-extended accumulator, modulo 65536.
- R8: Mode 5 (external data through the pointer) yields space 3 and address dptr.
- R9: Mode 6 (push) gives the request byte as a direct operand address, using the R4 space rule. It also sets out_stk_vld=1 with out_stk_addr equal to the stack pointer plus 1, and the stack pointer takes that value. Pushing the accumulator uses byte E0h, which lies in space 1.
- R10: Mode 7 (pop) gives the request byte as a direct destination and out_stk_addr equal to the current stack pointer. The stack pointer then drops by 1, wrapping modulo 256.
- R11: The outputs show a request on the clock edge after it is presented. A cycle with req_valid=0 leaves all outputs 0 on the next edge and does not change the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Operand mode code (0 to 7, see R2–R10) |
| req_byte | input | 8 | Instruction byte: immediate data or direct address |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | 16-bit data pointer |
| bank_sel | input | 2 | Active register bank |
| reg_sel | input | 3 | Register number within the bank |
| ptr_r0 | input | 8 | Contents of register 0 of the active bank |
| ptr_r1 | input | 8 | Contents of register 1 of the active bank |
| out_valid | output | 1 | A result is present |
| out_addr_vld | output | 1 | out_addr and out_space are meaningful |
| out_space | output | 2 | 0 internal RAM, 1 special registers, 2 code, 3 external data |
| out_addr | output | 16 | Operand address |
| out_illegal | output | 1 | Illegal pointer register named |
| out_stk_vld | output | 1 | A stack slot address is present |
| out_stk_addr | output | 8 | Stack slot in internal RAM |
| out_imm | output | 8 | Immediate operand byte |

## Verification
The bench aims at the 7Fh/80h edge, where a wrong comparison would send the top of internal RAM to the special registers. It also drives the indexed sum to FFFFh plus FFh, where a design without the modulo-65536 wrap would give a wrong code address. Pointer numbers 2–7 are sent in indirect mode, where a design that uses the low bit or forgets the check would return an address instead of flagging. Push and pop runs cross the 00h/FFh wrap of the stack pointer. A design with post-increment or pre-decrement would put every stack slot one place off.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_REG  = 3'd1,
    AM_DIR  = 3'd2,
    AM_IND  = 3'd3,
    AM_IDX  = 3'd4,
    AM_XDP  = 3'd5,
    AM_PUSH = 3'd6,
    AM_POP  = 3'd7
  } amode_t;

  typedef enum logic [1:0] {
    SPC_IRAM  = 2'd0,
    SPC_SFR   = 2'd1,
    SPC_CODE  = 2'd2,
    SPC_XDATA = 2'd3
  } aspace_t;
endpackage

// File: rtl/opnd_space_sel.sv
module opnd_space_sel
  import opnd_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [7:0]  SFR_BASE = 8'h80
) (
  input  logic [AW-1:0] a,
  output aspace_t       spc
);
  always_comb begin
    if (a >= AW'(SFR_BASE)) spc = SPC_SFR;
    else                    spc = SPC_IRAM;
  end
endmodule

// File: rtl/opnd_bank_map.sv
module opnd_bank_map #(
  parameter int BANK_W = 2,
  parameter int REG_W  = 3,
  parameter int OUT_W  = 8
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [REG_W-1:0]  rnum,
  output logic [OUT_W-1:0]  addr
);
  localparam int USED = BANK_W + REG_W;
  localparam int PAD  = OUT_W - USED;

  generate
    if (PAD > 0) begin : g_pad
      assign addr = {{PAD{1'b0}}, bank, rnum};
    end else begin : g_nopad
      assign addr = OUT_W'({bank, rnum});
    end
  endgenerate
endmodule

// File: rtl/opnd_index_add.sv
module opnd_index_add #(
  parameter int W     = 16,
  parameter int OFF_W = 8
) (
  input  logic [W-1:0]     base,
  input  logic [OFF_W-1:0] off,
  output logic [W-1:0]     sum
);
  localparam int PAD = W - OFF_W;
  logic [W-1:0] off_ext;

  assign off_ext = {{PAD{1'b0}}, off};
  assign sum     = base + off_ext;
endmodule

// File: rtl/opnd_stack_ptr.sv
module opnd_stack_ptr #(
  parameter int         W       = 8,
  parameter logic [7:0] RST_VAL = 8'h07
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] sp,
  output logic [W-1:0] sp_up
);
  assign sp_up = sp + W'(1);

  always_ff @(posedge clk) begin
    if (rst)      sp <= W'(RST_VAL);
    else if (inc) sp <= sp_up;
    else if (dec) sp <= sp - W'(1);
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         BANK_W   = 2,
  parameter int         REG_W    = 3,
  parameter logic [7:0] SFR_BASE = 8'h80,
  parameter logic [7:0] SP_INIT  = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic [7:0]        req_byte,
  input  logic [7:0]        acc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [7:0]        ptr_r0,
  input  logic [7:0]        ptr_r1,
  output logic              out_valid,
  output logic              out_addr_vld,
  output logic [1:0]        out_space,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_illegal,
  output logic              out_stk_vld,
  output logic [7:0]        out_stk_addr,
  output logic [7:0]        out_imm
);
  localparam int PAD = ADDR_W - BYTE_W;

  amode_t            mode;
  logic [7:0]        reg_addr;
  logic [7:0]        ind_ptr;
  aspace_t           dir_spc;
  aspace_t           ind_spc;
  logic [ADDR_W-1:0] idx_sum;
  logic [7:0]        sp_cur;
  logic [7:0]        sp_up;
  logic              do_push;
  logic              do_pop;
  logic              ind_ok;

  logic              n_addr_vld;
  aspace_t           n_space;
  logic [ADDR_W-1:0] n_addr;
  logic              n_illegal;
  logic              n_stk_vld;
  logic [7:0]        n_stk_addr;
  logic [7:0]        n_imm;

  assign mode    = amode_t'(req_mode);
  assign do_push = req_valid && (mode == AM_PUSH);
  assign do_pop  = req_valid && (mode == AM_POP);
  assign ind_ok  = (reg_sel[REG_W-1:1] == '0);
  assign ind_ptr = reg_sel[0] ? ptr_r1 : ptr_r0;

  opnd_bank_map #(.BANK_W(BANK_W), .REG_W(REG_W), .OUT_W(8)) u_bank (
    .bank (bank_sel),
    .rnum (reg_sel),
    .addr (reg_addr)
  );

  opnd_space_sel #(.AW(8), .SFR_BASE(SFR_BASE)) u_dir_spc (
    .a   (req_byte),
    .spc (dir_spc)
  );

  opnd_space_sel #(.AW(8), .SFR_BASE(SFR_BASE)) u_ind_spc (
    .a   (ind_ptr),
    .spc (ind_spc)
  );

  opnd_index_add #(.W(ADDR_W), .OFF_W(8)) u_idx (
    .base (dptr),
    .off  (acc),
    .sum  (idx_sum)
  );

  opnd_stack_ptr #(.W(8), .RST_VAL(SP_INIT)) u_sp (
    .clk   (clk),
    .rst   (rst),
    .inc   (do_push),
    .dec   (do_pop),
    .sp    (sp_cur),
    .sp_up (sp_up)
  );

  always_comb begin
    n_addr_vld = 1'b0;
    n_space    = SPC_IRAM;
    n_addr     = '0;
    n_illegal  = 1'b0;
    n_stk_vld  = 1'b0;
    n_stk_addr = '0;
    n_imm      = '0;
    if (req_valid) begin
      unique case (mode)
        AM_IMM: begin
          n_imm = req_byte;
        end
        AM_REG: begin
          n_addr_vld = 1'b1;
          n_space    = SPC_IRAM;
          n_addr     = {{PAD{1'b0}}, reg_addr};
        end
        AM_DIR: begin
          n_addr_vld = 1'b1;
          n_space    = dir_spc;
          n_addr     = {{PAD{1'b0}}, req_byte};
        end
        AM_IND: begin
          if (ind_ok) begin
            n_addr_vld = 1'b1;
            n_space    = ind_spc;
            n_addr     = {{PAD{1'b0}}, ind_ptr};
          end else begin
            n_illegal  = 1'b1;
          end
        end
        AM_IDX: begin
          n_addr_vld = 1'b1;
          n_space    = SPC_CODE;
          n_addr     = idx_sum;
        end
        AM_XDP: begin
          n_addr_vld = 1'b1;
          n_space    = SPC_XDATA;
          n_addr     = dptr;
        end
        AM_PUSH: begin
          n_addr_vld = 1'b1;
          n_space    = dir_spc;
          n_addr     = {{PAD{1'b0}}, req_byte};
          n_stk_vld  = 1'b1;
          n_stk_addr = sp_up;
        end
        AM_POP: begin
          n_addr_vld = 1'b1;
          n_space    = dir_spc;
          n_addr     = {{PAD{1'b0}}, req_byte};
          n_stk_vld  = 1'b1;
          n_stk_addr = sp_cur;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr_vld <= 1'b0;
      out_space    <= '0;
      out_addr     <= '0;
      out_illegal  <= 1'b0;
      out_stk_vld  <= 1'b0;
      out_stk_addr <= '0;
      out_imm      <= '0;
    end else begin
      out_valid    <= req_valid;
      out_addr_vld <= n_addr_vld;
      out_space    <= n_space;
      out_addr     <= n_addr;
      out_illegal  <= n_illegal;
      out_stk_vld  <= n_stk_vld;
      out_stk_addr <= n_stk_addr;
      out_imm      <= n_imm;
    end
  end
endmodule

// File: rtl/opnd_addr_gen_chk.sv
module opnd_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_mode,
  input logic [7:0]        req_byte,
  input logic [7:0]        acc,
  input logic [ADDR_W-1:0] dptr,
  input logic [BANK_W-1:0] bank_sel,
  input logic [REG_W-1:0]  reg_sel,
  input logic              out_valid,
  input logic              out_addr_vld,
  input logic [1:0]        out_space,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_illegal,
  input logic              out_stk_vld,
  input logic [7:0]        out_stk_addr
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_addr_vld && !out_stk_vld && !out_illegal));

  a_r6_bad_pointer: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 3'd3 && reg_sel > 3'd1) |=> (out_illegal && !out_addr_vld));

  a_r5_ind_internal: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 3'd3) |=> (out_space == 2'd0 || out_space == 2'd1));

  a_r7_idx_code: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 3'd4) |=>
      (out_space == 2'd2 && out_addr == $past(dptr) + {{(ADDR_W-8){1'b0}}, $past(acc)}));

  a_r9_push_chain: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 3'd6 && out_stk_vld && $past(req_valid && req_mode == 3'd6))
      |=> (out_stk_addr == $past(out_stk_addr) + 8'd1));

  a_r10_pop_chain: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 3'd7 && out_stk_vld && $past(req_valid && req_mode == 3'd7))
      |=> (out_stk_addr == $past(out_stk_addr) - 8'd1));

  a_r4_direct_split: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 3'd2) |=> (out_space == {1'b0, $past(req_byte[7])}));
endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_mode     (req_mode),
  .req_byte     (req_byte),
  .acc          (acc),
  .dptr         (dptr),
  .bank_sel     (bank_sel),
  .reg_sel      (reg_sel),
  .out_valid    (out_valid),
  .out_addr_vld (out_addr_vld),
  .out_space    (out_space),
  .out_addr     (out_addr),
  .out_illegal  (out_illegal),
  .out_stk_vld  (out_stk_vld),
  .out_stk_addr (out_stk_addr)
);

// File: tb/sim_opnd_addr_gen.sv
module sim_opnd_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [7:0]  req_byte = '0;
  logic [7:0]  acc = '0;
  logic [15:0] dptr = '0;
  logic [1:0]  bank_sel = '0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  ptr_r0 = '0;
  logic [7:0]  ptr_r1 = '0;
  logic        out_valid, out_addr_vld, out_illegal, out_stk_vld;
  logic [1:0]  out_space;
  logic [15:0] out_addr;
  logic [7:0]  out_stk_addr, out_imm;

  int total = 0;
  int bad = 0;
  logic [7:0]  sp_model = 8'h07;
  logic [37:0] exp_vec;
  logic [2:0]  exp_mode;
  logic        pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_byte(req_byte), .acc(acc), .dptr(dptr), .bank_sel(bank_sel),
    .reg_sel(reg_sel), .ptr_r0(ptr_r0), .ptr_r1(ptr_r1),
    .out_valid(out_valid), .out_addr_vld(out_addr_vld), .out_space(out_space),
    .out_addr(out_addr), .out_illegal(out_illegal), .out_stk_vld(out_stk_vld),
    .out_stk_addr(out_stk_addr), .out_imm(out_imm)
  );

  function automatic string tag_of(input logic v, input logic [2:0] m, input logic [2:0] r);
    if (!v) return "R11";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return (r > 3'd1) ? "R6" : "R5";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [1:0] split(input logic [7:0] a);
    return (a >= 8'h80) ? 2'd1 : 2'd0;
  endfunction

  // fields: valid, addr_vld, space[2], addr[16], illegal, stk_vld, stk_addr[8], imm[8]
  function automatic logic [37:0] model(input logic v, input logic [2:0] m,
      input logic [7:0] b, input logic [7:0] a, input logic [15:0] dp,
      input logic [1:0] bk, input logic [2:0] r, input logic [7:0] p0,
      input logic [7:0] p1, input logic [7:0] sp);
    logic av, il, sv; logic [1:0] s; logic [15:0] ad; logic [7:0] sa, im;
    logic [7:0] p;
    av = 0; il = 0; sv = 0; s = 0; ad = 0; sa = 0; im = 0;
    if (v) begin
      case (m)
        3'd0: im = b;
        3'd1: begin av = 1; ad = 16'(bk) * 16'd8 + 16'(r); end
        3'd2: begin av = 1; s = split(b); ad = {8'h00, b}; end
        3'd3: if (r <= 3'd1) begin
                p = (r == 3'd1) ? p1 : p0;
                av = 1; s = split(p); ad = {8'h00, p};
              end else il = 1;
        3'd4: begin av = 1; s = 2'd2; ad = 16'((17'(dp) + 17'(a)) % 17'd65536); end
        3'd5: begin av = 1; s = 2'd3; ad = dp; end
        3'd6: begin av = 1; s = split(b); ad = {8'h00, b}; sv = 1; sa = sp + 8'd1; end
        default: begin av = 1; s = split(b); ad = {8'h00, b}; sv = 1; sa = sp; end
      endcase
    end
    return {v, av, s, ad, il, sv, sa, im};
  endfunction

  function automatic logic [37:0] actual();
    return {out_valid, out_addr_vld, out_space, out_addr, out_illegal,
            out_stk_vld, out_stk_addr, out_imm};
  endfunction

  task automatic check_pending(input string tg);
    total++;
    if (actual() !== exp_vec) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tg, actual(), exp_vec);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] m, input logic [7:0] b,
      input logic [7:0] a, input logic [15:0] dp, input logic [1:0] bk,
      input logic [2:0] r, input logic [7:0] p0, input logic [7:0] p1);
    @(negedge clk);
    if (pend) check_pending(tag_of(exp_vec[37], exp_mode, reg_sel));
    req_valid = v; req_mode = m; req_byte = b; acc = a; dptr = dp;
    bank_sel = bk; reg_sel = r; ptr_r0 = p0; ptr_r1 = p1;
    exp_vec = model(v, m, b, a, dp, bk, r, p0, p1, sp_model);
    exp_mode = m;
    if (v && m == 3'd6) sp_model = sp_model + 8'd1;
    if (v && m == 3'd7) sp_model = sp_model - 8'd1;
    pend = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_vec = '0;
    check_pending("R1");
    rst = 1'b0;
    // R1: first push from reset lands at 08h; R9: push accumulator E0h
    step(1, 3'd6, 8'hE0, 0, 0, 0, 0, 0, 0);
    step(1, 3'd7, 8'h04, 0, 0, 0, 0, 0, 0);   // R10
    step(1, 3'd0, 8'h5A, 0, 0, 0, 0, 0, 0);   // R2
    step(1, 3'd1, 8'h00, 0, 0, 2'd3, 3'd7, 0, 0); // R3 -> 1Fh
    step(1, 3'd1, 8'h00, 0, 0, 2'd0, 3'd4, 0, 0); // R3 -> 04h
    step(1, 3'd2, 8'h7F, 0, 0, 0, 0, 0, 0);   // R4 top of RAM
    step(1, 3'd2, 8'h80, 0, 0, 0, 0, 0, 0);   // R4 first special reg
    step(1, 3'd3, 0, 0, 0, 0, 3'd0, 8'h7F, 8'h80); // R5
    step(1, 3'd3, 0, 0, 0, 0, 3'd1, 8'h7F, 8'h80); // R5
    step(1, 3'd3, 0, 0, 0, 0, 3'd2, 8'h10, 8'h11); // R6
    step(1, 3'd3, 0, 0, 0, 0, 3'd7, 8'h10, 8'h11); // R6
    step(1, 3'd4, 0, 8'hFF, 16'hFFFF, 0, 0, 0, 0); // R7 wrap -> 00FEh
    step(1, 3'd5, 0, 8'h33, 16'hBEEF, 0, 0, 0, 0); // R8
    step(0, 3'd6, 8'h22, 0, 0, 0, 0, 0, 0);   // R11 idle, no SP change
    // R10: pop across 00h/FFh wrap
    for (int i = 0; i < 10; i++) step(1, 3'd7, 8'h30, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 3'd6, 8'h31, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) != 0, 3'($urandom), 8'($urandom), 8'($urandom),
           16'($urandom), 2'($urandom), 3'($urandom), 8'($urandom), 8'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule